// File: doc/BRIEF.md
# UART Status Flags and Clear Sequencing

This block keeps the five status flags of a UART that can run full duplex or on a single shared wire. The transmit side has two flags: "holding register empty" and "transmission complete". The receive side has three error flags: framing, noise and parity. The block takes one-cycle event strobes from a transmit shifter and a receive framer, and one-cycle strobes from the bus side: a status read, a data write, a queued preamble, a queued break, and an error clear. Each flag drives an interrupt line that is gated by its own enable bit. The block also decides whether the transmit pin is driven.

Transmission complete uses a two-step clear. A status read taken while the flag is 1 arms the clear. The next data write, preamble request or break request then clears the flag and uses up the arm. The arm is also dropped whenever the flag is set again, so every clear needs its own read. While a framing error is pending, the block discards received characters, and noise or parity found in those characters does not set a flag. Clearing the errors clears all three receive error flags together.

Top module: `uart_status_flags`

## Requirements
- R1: After reset, `flags` equals 5'b00011. Bit 0 is holding-empty, bit 1 is complete, bit 2 is framing, bit 3 is noise and bit 4 is parity. Holding-empty and complete reset to 1 and the error flags reset to 0.
- R2: A data write, preamble request or break request does not clear complete (bit 1) unless an earlier status read saw complete at 1 and no new set has happened since that read.
- R3: Once armed, any one of the three actions clears complete on the next edge and uses up the arm. A status read in the same cycle as an action does not arm that action.
- R4: A `tx_idle` strobe sets complete and drops any arm. If `tx_idle` arrives in the same cycle as an armed action, complete stays 1.
- R5: `data_wr` clears holding-empty. `tx_char_done` sets it whether or not the pin is driven. When both strobe in the same cycle, `tx_char_done` wins.
- R6: While framing (bit 2) is 1 and no `err_clr` is present, `rx_accept` stays 0 for a strobed character. The noise and parity flags keep their values.
- R7: While framing is 0, a `rx_valid` character raises `rx_accept` in the same cycle. On the next edge it ORs `rx_frame_err`, `rx_noise` and `rx_parity_err` into bits 2, 3 and 4, and those bits stay set.
- R8: `err_clr` clears bits 2 to 4. A character strobed in the same cycle is judged against the cleared state, so it is accepted and its error bits are recorded.
- R9: `irq[i]` equals `flags[i] & irq_en[i]` for every bit.
- R10: `txd_oe` is 1 when `single_wire` is 0. When `single_wire` is 1, `txd_oe` equals `tx_dir` (1 = transmit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_char_done | input | 1 | Shifter finished a character |
| tx_idle | input | 1 | Transmitter went idle (sets complete) |
| stat_rd | input | 1 | Status register read strobe |
| data_wr | input | 1 | Data register write strobe |
| pre_q | input | 1 | Preamble queue request |
| brk_q | input | 1 | Break queue request |
| err_clr | input | 1 | Receive error clear strobe |
| rx_valid | input | 1 | Framer delivers a character |
| rx_frame_err | input | 1 | Character had a bad stop bit |
| rx_noise | input | 1 | Character had noise |
| rx_parity_err | input | 1 | Character had a parity mismatch |
| single_wire | input | 1 | Half-duplex shared-pin mode |
| tx_dir | input | 1 | Pin direction in single-wire mode, 1 = drive |
| irq_en | input | 5 | Per-flag interrupt enables |
| flags | output | 5 | Status flags |
| irq | output | 5 | Gated interrupt requests |
| rx_accept | output | 1 | Character is passed to the receive data path |
| txd_oe | output | 1 | Transmit pin output enable |

## Verification
The assertions assume that every strobe lasts one cycle and that the receive error qualifiers matter only while `rx_valid` is high. They also assume that the mode and direction inputs are steady levels. The bench drives every input on the falling edge and holds each strobe for exactly one cycle, which keeps it within these assumptions. The bench walks through all three clearing actions, every combination of receive error bits, all 32 enable masks and all four pin modes. It also covers the same-cycle collisions between sets, clears and accepts.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned NFLAG   = 5;
  localparam int unsigned F_TDRE  = 0;
  localparam int unsigned F_TC    = 1;
  localparam int unsigned F_FE    = 2;
  localparam int unsigned F_NF    = 3;
  localparam int unsigned F_PE    = 4;
  localparam logic [NFLAG-1:0] FLAG_RST = 5'b00011;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/uart_txflag_ctrl.sv
module uart_txflag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_char_done,
  input  logic tx_idle,
  input  logic stat_rd,
  input  logic data_wr,
  input  logic pre_q,
  input  logic brk_q,
  output logic tdre,
  output logic tc,
  output logic tc_armed
);
  logic tdre_q, tdre_d, tdre_en;
  logic tc_q, tc_d, tc_en;
  logic arm_q, arm_d, arm_en;
  logic act, fire;

  always_comb begin
    act  = data_wr | pre_q | brk_q;
    fire = act & arm_q;
    // holding-empty: shifter completion wins over a write
    tdre_en = tx_char_done | data_wr;
    tdre_d  = tx_char_done;
    // complete: new set wins over an armed clear
    tc_en = tx_idle | fire;
    tc_d  = tx_idle;
    // arm: dropped on set or use, taken by a read that sees complete
    arm_en = tx_idle | fire | (stat_rd & tc_q);
    arm_d  = ~(tx_idle | fire);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre_q <= 1'b1;
      tc_q   <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      if (tdre_en) tdre_q <= tdre_d;
      if (tc_en)   tc_q   <= tc_d;
      if (arm_en)  arm_q  <= arm_d;
    end
  end

  assign tdre     = tdre_q;
  assign tc       = tc_q;
  assign tc_armed = arm_q;
endmodule

// File: rtl/uart_rxerr_flags.sv
module uart_rxerr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic err_clr,
  input  logic rx_valid,
  input  logic rx_frame_err,
  input  logic rx_noise,
  input  logic rx_parity_err,
  output logic fe,
  output logic nf,
  output logic pe,
  output logic rx_accept
);
  logic fe_q, nf_q, pe_q;
  logic fe_d, nf_d, pe_d;
  logic fe_base, nf_base, pe_base, take, upd_en;

  always_comb begin
    fe_base = fe_q & ~err_clr;
    nf_base = nf_q & ~err_clr;
    pe_base = pe_q & ~err_clr;
    take    = rx_valid & ~fe_base;
    fe_d    = fe_base | (take & rx_frame_err);
    nf_d    = nf_base | (take & rx_noise);
    pe_d    = pe_base | (take & rx_parity_err);
    upd_en  = err_clr | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q <= 1'b0;
      nf_q <= 1'b0;
      pe_q <= 1'b0;
    end else if (upd_en) begin
      fe_q <= fe_d;
      nf_q <= nf_d;
      pe_q <= pe_d;
    end
  end

  assign fe        = fe_q;
  assign nf        = nf_q;
  assign pe        = pe_q;
  assign rx_accept = take;
endmodule

// File: rtl/uart_pin_dir.sv
module uart_pin_dir (
  input  logic single_wire,
  input  logic tx_dir,
  output logic txd_oe
);
  always_comb txd_oe = single_wire ? tx_dir : 1'b1;
endmodule

// File: rtl/uart_status_flags.sv
module uart_status_flags
  import uart_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_char_done,
  input  logic             tx_idle,
  input  logic             stat_rd,
  input  logic             data_wr,
  input  logic             pre_q,
  input  logic             brk_q,
  input  logic             err_clr,
  input  logic             rx_valid,
  input  logic             rx_frame_err,
  input  logic             rx_noise,
  input  logic             rx_parity_err,
  input  logic             single_wire,
  input  logic             tx_dir,
  input  logic [NFLAG-1:0] irq_en,
  output logic [NFLAG-1:0] flags,
  output logic [NFLAG-1:0] irq,
  output logic             rx_accept,
  output logic             txd_oe
);
  flag_vec_t fl;
  logic      tc_armed;

  uart_txflag_ctrl u_tx (
    .clk(clk), .rst_n(rst_n), .tx_char_done(tx_char_done), .tx_idle(tx_idle),
    .stat_rd(stat_rd), .data_wr(data_wr), .pre_q(pre_q), .brk_q(brk_q),
    .tdre(fl[F_TDRE]), .tc(fl[F_TC]), .tc_armed(tc_armed)
  );

  uart_rxerr_flags u_rx (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr), .rx_valid(rx_valid),
    .rx_frame_err(rx_frame_err), .rx_noise(rx_noise), .rx_parity_err(rx_parity_err),
    .fe(fl[F_FE]), .nf(fl[F_NF]), .pe(fl[F_PE]), .rx_accept(rx_accept)
  );

  uart_pin_dir u_pin (
    .single_wire(single_wire), .tx_dir(tx_dir), .txd_oe(txd_oe)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_irq
    assign irq[i] = fl[i] & irq_en[i];
  end

  assign flags = fl;
endmodule

// File: rtl/uart_status_flags_chk.sv
module uart_status_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_idle,
  input logic       data_wr,
  input logic       pre_q,
  input logic       brk_q,
  input logic       err_clr,
  input logic       rx_valid,
  input logic       single_wire,
  input logic       tx_dir,
  input logic [4:0] flags,
  input logic       rx_accept,
  input logic       txd_oe,
  input logic       tc_armed
);
  AST_TC_CLEAR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[1]) |-> ($past(tc_armed) && $past(data_wr | pre_q | brk_q))); // R2
  AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |=> flags[1]); // R4
  AST_FE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && flags[2] && !err_clr) |-> !rx_accept); // R6
  AST_NF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !err_clr) |=> !$rose(flags[3])); // R6
  AST_PE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[2] && !err_clr) |=> !$rose(flags[4])); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_valid) |=> (flags[4:2] == 3'b000)); // R8
  AST_PIN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !single_wire |-> txd_oe); // R10
  AST_PIN_RX: assert property (@(posedge clk) disable iff (!rst_n)
    (single_wire && !tx_dir) |-> !txd_oe); // R10
endmodule

bind uart_status_flags uart_status_flags_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_idle(tx_idle), .data_wr(data_wr), .pre_q(pre_q),
  .brk_q(brk_q), .err_clr(err_clr), .rx_valid(rx_valid), .single_wire(single_wire),
  .tx_dir(tx_dir), .flags(flags), .rx_accept(rx_accept), .txd_oe(txd_oe),
  .tc_armed(tc_armed)
);

// File: tb/uart_status_flags_bench.sv
module uart_status_flags_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic tx_char_done, tx_idle, stat_rd, data_wr, pre_q, brk_q, err_clr;
  logic rx_valid, rx_frame_err, rx_noise, rx_parity_err, single_wire, tx_dir;
  logic [4:0] irq_en, flags, irq;
  logic rx_accept, txd_oe;
  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_status_flags u_uart_status_flags (
    .clk(clk), .rst_n(rst_n), .tx_char_done(tx_char_done), .tx_idle(tx_idle),
    .stat_rd(stat_rd), .data_wr(data_wr), .pre_q(pre_q), .brk_q(brk_q),
    .err_clr(err_clr), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err),
    .rx_noise(rx_noise), .rx_parity_err(rx_parity_err), .single_wire(single_wire),
    .tx_dir(tx_dir), .irq_en(irq_en), .flags(flags), .irq(irq),
    .rx_accept(rx_accept), .txd_oe(txd_oe)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung act=%0d exp=0", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    tx_char_done = 0; tx_idle = 0; stat_rd = 0; data_wr = 0; pre_q = 0; brk_q = 0;
    err_clr = 0; rx_valid = 0; rx_frame_err = 0; rx_noise = 0; rx_parity_err = 0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle_in();
  endtask

  task automatic action(int a);
    case (a)
      0: data_wr = 1;
      1: pre_q = 1;
      default: brk_q = 1;
    endcase
  endtask

  initial begin
    idle_in();
    single_wire = 0; tx_dir = 0; irq_en = 5'b0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1 reset flags", flags, 5'b00011);

    // R10 pin enable sweep
    for (int m = 0; m < 4; m++) begin
      single_wire = m[1]; tx_dir = m[0];
      #1 chk("R10 txd_oe", txd_oe, (!m[1]) | m[0]);
    end
    single_wire = 0; tx_dir = 0;

    // R9 enable sweep at reset flags
    for (int e = 0; e < 32; e++) begin
      irq_en = e[4:0];
      #1 chk("R9 irq gate", irq, e[4:0] & 5'b00011);
    end

    // R2 action without a prior read leaves complete set
    for (int a = 0; a < 3; a++) begin
      action(a); tick();
      chk("R2 unarmed action", flags[1], 1'b1);
    end
    // R3 read and action in the same cycle does not clear
    stat_rd = 1; pre_q = 1; tick();
    chk("R3 same-cycle read", flags[1], 1'b1);
    pre_q = 1; tick();
    chk("R3 armed by earlier read", flags[1], 1'b0);

    // R3 each action clears once armed; R4 set drops arm
    for (int a = 0; a < 3; a++) begin
      tx_idle = 1; tick();
      chk("R4 set complete", flags[1], 1'b1);
      stat_rd = 1; tick();
      action(a); tick();
      chk("R3 armed clear", flags[1], 1'b0);
      tx_idle = 1; tick();
      action(a); tick();
      chk("R4 re-set needs read", flags[1], 1'b1);
    end
    // R4 read, then set, then action
    stat_rd = 1; tick();
    tx_idle = 1; tick();
    brk_q = 1; tick();
    chk("R4 set drops arm", flags[1], 1'b1);
    // R4 set in same cycle as armed action
    stat_rd = 1; tick();
    data_wr = 1; tx_idle = 1; tick();
    chk("R4 set wins", flags[1], 1'b1);
    pre_q = 1; tick();
    chk("R4 arm consumed by collision", flags[1], 1'b1);

    // R5 holding-empty, pin undriven in single-wire receive direction
    single_wire = 1; tx_dir = 0;
    tx_char_done = 1; tick();
    data_wr = 1; tick();
    chk("R5 write clears", flags[0], 1'b0);
    #1 chk("R10 pin off while shifting", txd_oe, 1'b0);
    tx_char_done = 1; tick();
    chk("R5 done sets undriven", flags[0], 1'b1);
    data_wr = 1; tx_char_done = 1; tick();
    chk("R5 done wins", flags[0], 1'b1);
    single_wire = 0;

    // R6 R7 R8 receive error sweep
    irq_en = 5'b11111;
    for (int c = 0; c < 8; c++) begin
      logic [2:0] exp_e;
      err_clr = 1; tick();
      chk("R8 clear", flags[4:2], 3'b000);
      rx_valid = 1; rx_frame_err = c[0]; rx_noise = c[1]; rx_parity_err = c[2];
      #1 chk("R7 accept", rx_accept, 1'b1);
      tick();
      chk("R7 record", flags[4:2], c[2:0]);
      exp_e = c[2:0];
      rx_valid = 1; rx_noise = 1; rx_parity_err = 1;
      if (c[0]) begin
        #1 chk("R6 discard", rx_accept, 1'b0);
      end else begin
        exp_e = exp_e | 3'b110;
      end
      tick();
      chk(c[0] ? "R6 errors held" : "R7 sticky OR", flags[4:2], exp_e);
      #1 chk("R9 irq follows", irq, flags);
    end
    // R8 clear and character in the same cycle
    err_clr = 1; rx_valid = 1; rx_parity_err = 1;
    #1 chk("R8 accept with clear", rx_accept, 1'b1);
    tick();
    chk("R8 judged after clear", flags[4:2], 3'b100);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule